// File: doc/BRIEF.md
# Split Tag/Data Cache Write Sequencer

This block sequences write hits to an external second-level cache built from synchronous SRAM. The tag array and the data array sit on separate address and data buses. Each accepted write request becomes two separate SRAM transactions. The first reads the tag and state of the line. The second writes the data array, and it is issued only when the stored tag matches and the line is held Exclusive or Modified. On the data bus the address (with its write strobe) leads the write data by one SRAM cycle, so a read that ends just before a write needs less bus turnaround.

Requests arrive over a valid/ready handshake. The request address is split into a line index, which drives both SRAM address buses, and a tag part, which is compared with the stored tag. The block runs in two modes. In full-speed mode one SRAM cycle is one core clock and a new tag access can start every clock. In half-speed mode one SRAM cycle is two core clocks. Outcomes that cannot be written (tag mismatch, or a line that is Invalid or Shared) raise a one-clock miss pulse, and nothing is written to the data array.

Top module: `l2_wr_sequencer`

## Requirements
- R1: While reset is high, and in the first sample after reset, `tag_oe_n` and `dat_we_n` are 1, `dat_oe` and `miss_pulse` are 0, and `dat_wdata` is zero.
- R2: A request accepted at a clock edge drives `tag_oe_n` low for the next SRAM cycle (T0), with the index `req_addr[IDX_W-1:0]` on `tag_addr`. The tag SRAM returns the line during T1.
- R3: The block samples the returned line at the end of T1 and decides in T2. The access is writable only if `tag_rd_tag` equals `req_addr[ADDR_W-1:IDX_W]` and `tag_rd_state` is 2 (Exclusive) or 3 (Modified). The state codes are 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.
- R4: For a writable access, T3 is the internal write-request cycle. In T4, `dat_we_n` is low and `dat_addr` carries the index.
- R5: In T5, the SRAM cycle after the data address, `dat_oe` is 1 and `dat_wdata` carries the request data. At all other times `dat_oe` is 0 and `dat_wdata` is zero.
- R6: For a non-writable access, `miss_pulse` is 1 for exactly one core clock, the first clock of T3. In T4 and T5 that access leaves `dat_we_n` at 1 and `dat_oe` at 0.
- R7: In full-speed mode (`half_speed`=0), `req_ready` is 1 every clock. Back-to-back requests start tag reads on consecutive clocks, and each one finishes with its own outcome.
- R8: In half-speed mode (`half_speed`=1), core clocks pair up from reset release and an SRAM cycle ends after the second clock of each pair. `req_ready` is 1 only on that second clock. Every SRAM-side output holds its value for both clocks of an SRAM cycle.
- R9: In a mixed stream of writable and non-writable requests, data writes appear on the data bus in request order, one per writable request and none for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| half_speed | input | 1 | 1 selects two core clocks per SRAM cycle; change only while idle and under reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | ADDR_W | Line address: upper bits are the tag, lower IDX_W bits the index |
| req_data | input | DATA_W | Write data |
| tag_oe_n | output | 1 | Active-low tag SRAM read enable |
| tag_addr | output | IDX_W | Tag SRAM address |
| tag_rd_tag | input | ADDR_W-IDX_W | Stored tag returned by the tag SRAM |
| tag_rd_state | input | 2 | Stored line state returned by the tag SRAM |
| dat_we_n | output | 1 | Active-low data SRAM write enable |
| dat_addr | output | IDX_W | Data SRAM address |
| dat_wdata | output | DATA_W | Write data toward the data SRAM |
| dat_oe | output | 1 | Write data bus drive enable |
| miss_pulse | output | 1 | One-clock pulse for a miss or a needed upgrade |

## Verification
The hardest case to bring about is a stream in which hits and non-writable outcomes are interleaved with no gap. Here the miss slot of one request sits directly between the data phases of its neighbours, so a stale valid bit or a misrouted data word would show up only at that boundary. The bench pushes hit, Shared-state miss and hit on consecutive clocks by holding `req_valid` high across the burst. It checks the strobe and data in each request's own SRAM cycle and also counts every write strobe in the window. In half-speed mode the same alignment is reached by holding requests until `req_ready` rises on the second clock of a pair.

// File: rtl/l2w_pkg.sv
package l2w_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_state_e;

  // A line may take a write without a coherence transaction only when owned
  function automatic logic state_writable(input logic [1:0] st);
    return (st == LS_EXC) || (st == LS_MOD);
  endfunction

endpackage

// File: rtl/l2w_cycle_gen.sv
module l2w_cycle_gen (
  input  logic clk,
  input  logic rst,
  input  logic half_speed,
  output logic adv
);

  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
    end else if (half_speed) begin
      phase_q <= ~phase_q;
    end else begin
      phase_q <= 1'b0;
    end
  end

  // SRAM cycle boundary: every clock at full speed, every second clock at half
  assign adv = ~half_speed | phase_q;

  AST_HALF_NO_DOUBLE_ADV: assert property (@(posedge clk) disable iff (rst)
    (half_speed && adv) |=> (!adv || !half_speed)); // R8

endmodule

// File: rtl/l2w_tag_path.sv
module l2w_tag_path #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              acc,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  input  logic [1:0]        tag_rd_state,
  output logic              tag_oe_n,
  output logic [IDX_W-1:0]  tag_addr,
  output logic              dec_valid,
  output logic              dec_hit,
  output logic [IDX_W-1:0]  dec_idx,
  output logic [DATA_W-1:0] dec_data
);

  import l2w_pkg::*;

  // T0: tag read issued on the pins
  logic              iss_v;
  logic [IDX_W-1:0]  iss_idx;
  logic [TAG_W-1:0]  iss_tag;
  logic [DATA_W-1:0] iss_dat;
  logic              oe_n_q;
  logic [IDX_W-1:0]  taddr_q;
  // T1: tag SRAM returns the line
  logic              ret_v;
  logic [IDX_W-1:0]  ret_idx;
  logic [TAG_W-1:0]  ret_tag;
  logic [DATA_W-1:0] ret_dat;
  // T2: captured line, compare and state check
  logic              dcd_v;
  logic [IDX_W-1:0]  dcd_idx;
  logic [TAG_W-1:0]  dcd_tag;
  logic [DATA_W-1:0] dcd_dat;
  logic [TAG_W-1:0]  dcd_rtag;
  logic [1:0]        dcd_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_v   <= 1'b0;
      iss_idx <= '0;
      iss_tag <= '0;
      iss_dat <= '0;
      oe_n_q  <= 1'b1;
      taddr_q <= '0;
    end else if (adv) begin
      iss_v   <= acc;
      iss_idx <= acc_idx;
      iss_tag <= acc_tag;
      iss_dat <= acc_data;
      oe_n_q  <= ~acc;
      taddr_q <= acc ? acc_idx : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_v   <= 1'b0;
      ret_idx <= '0;
      ret_tag <= '0;
      ret_dat <= '0;
    end else if (adv) begin
      ret_v   <= iss_v;
      ret_idx <= iss_idx;
      ret_tag <= iss_tag;
      ret_dat <= iss_dat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcd_v    <= 1'b0;
      dcd_idx  <= '0;
      dcd_tag  <= '0;
      dcd_dat  <= '0;
      dcd_rtag <= '0;
      dcd_rst  <= '0;
    end else if (adv) begin
      dcd_v    <= ret_v;
      dcd_idx  <= ret_idx;
      dcd_tag  <= ret_tag;
      dcd_dat  <= ret_dat;
      dcd_rtag <= tag_rd_tag;
      dcd_rst  <= tag_rd_state;
    end
  end

  assign tag_oe_n  = oe_n_q;
  assign tag_addr  = taddr_q;
  assign dec_valid = dcd_v;
  assign dec_hit   = (dcd_rtag == dcd_tag) && state_writable(dcd_rst);
  assign dec_idx   = dcd_idx;
  assign dec_data  = dcd_dat;

  AST_TAG_ADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !tag_oe_n |-> !$isunknown(tag_addr)); // R2

  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(tag_oe_n) && $stable(tag_addr))); // R8

endmodule

// File: rtl/l2w_data_path.sv
module l2w_data_path #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              dec_valid,
  input  logic              dec_hit,
  input  logic [IDX_W-1:0]  dec_idx,
  input  logic [DATA_W-1:0] dec_data,
  output logic              miss_pulse,
  output logic              dat_we_n,
  output logic [IDX_W-1:0]  dat_addr,
  output logic [DATA_W-1:0] dat_wdata,
  output logic              dat_oe
);

  // T3: internal write request
  logic              rq_v;
  logic [IDX_W-1:0]  rq_idx;
  logic [DATA_W-1:0] rq_dat;
  // T4: address and strobe on the pins
  logic              ad_v;
  logic [DATA_W-1:0] ad_dat;
  logic              we_n_q;
  logic [IDX_W-1:0]  addr_q;
  // T5: data on the pins
  logic              oe_q;
  logic [DATA_W-1:0] wd_q;
  logic              miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_v   <= 1'b0;
      rq_idx <= '0;
      rq_dat <= '0;
    end else if (adv) begin
      rq_v   <= dec_valid & dec_hit;
      rq_idx <= dec_idx;
      rq_dat <= dec_data;
    end
  end

  // One core clock wide, on the first clock of the request cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      miss_q <= 1'b0;
    end else begin
      miss_q <= adv & dec_valid & ~dec_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_v   <= 1'b0;
      ad_dat <= '0;
      we_n_q <= 1'b1;
      addr_q <= '0;
    end else if (adv) begin
      ad_v   <= rq_v;
      ad_dat <= rq_dat;
      we_n_q <= ~rq_v;
      addr_q <= rq_v ? rq_idx : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
      wd_q <= '0;
    end else if (adv) begin
      oe_q <= ad_v;
      wd_q <= ad_v ? ad_dat : '0;
    end
  end

  assign miss_pulse = miss_q;
  assign dat_we_n   = we_n_q;
  assign dat_addr   = addr_q;
  assign dat_wdata  = wd_q;
  assign dat_oe     = oe_q;

  AST_NO_WRITE_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    miss_pulse |-> !rq_v); // R6

  AST_DATA_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (adv && !dat_we_n) |=> dat_oe); // R5

  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dat_oe |-> (dat_wdata == '0)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(dat_we_n) && $stable(dat_addr) && $stable(dat_oe) && $stable(dat_wdata))); // R8

endmodule

// File: rtl/l2_wr_sequencer.sv
module l2_wr_sequencer #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_speed,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              tag_oe_n,
  output logic [IDX_W-1:0]  tag_addr,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  input  logic [1:0]        tag_rd_state,
  output logic              dat_we_n,
  output logic [IDX_W-1:0]  dat_addr,
  output logic [DATA_W-1:0] dat_wdata,
  output logic              dat_oe,
  output logic              miss_pulse
);

  logic              adv;
  logic              acc;
  logic              dec_valid;
  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [DATA_W-1:0] dec_data;

  l2w_cycle_gen u_cyc (
    .clk        (clk),
    .rst        (rst),
    .half_speed (half_speed),
    .adv        (adv)
  );

  // Fixed-latency stages never stall: a slot opens at every SRAM cycle boundary
  assign req_ready = adv;
  assign acc       = req_valid & adv;

  l2w_tag_path #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_tag (
    .clk          (clk),
    .rst          (rst),
    .adv          (adv),
    .acc          (acc),
    .acc_idx      (req_addr[IDX_W-1:0]),
    .acc_tag      (req_addr[ADDR_W-1:IDX_W]),
    .acc_data     (req_data),
    .tag_rd_tag   (tag_rd_tag),
    .tag_rd_state (tag_rd_state),
    .tag_oe_n     (tag_oe_n),
    .tag_addr     (tag_addr),
    .dec_valid    (dec_valid),
    .dec_hit      (dec_hit),
    .dec_idx      (dec_idx),
    .dec_data     (dec_data)
  );

  l2w_data_path #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_dat (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .dec_valid  (dec_valid),
    .dec_hit    (dec_hit),
    .dec_idx    (dec_idx),
    .dec_data   (dec_data),
    .miss_pulse (miss_pulse),
    .dat_we_n   (dat_we_n),
    .dat_addr   (dat_addr),
    .dat_wdata  (dat_wdata),
    .dat_oe     (dat_oe)
  );

  AST_READY_HALF_ALT: assert property (@(posedge clk) disable iff (rst)
    (half_speed && req_ready) |=> (!req_ready || !half_speed)); // R8

  AST_READY_FULL: assert property (@(posedge clk) disable iff (rst)
    !half_speed |-> req_ready); // R7

  AST_WE_OE_EXCLUSIVE_MISS: assert property (@(posedge clk) disable iff (rst)
    (!half_speed && miss_pulse) |=> dat_we_n); // R6

endmodule

// File: tb/l2_wr_sequencer_tb.sv
`timescale 1ns/1ps
module l2_wr_sequencer_tb;

  localparam int ADDR_W = 20;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 32;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LOGN   = 4096;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              half_speed = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic              tag_oe_n;
  logic [IDX_W-1:0]  tag_addr;
  logic [TAG_W-1:0]  tag_rd_tag = '0;
  logic [1:0]        tag_rd_state = '0;
  logic              dat_we_n;
  logic [IDX_W-1:0]  dat_addr;
  logic [DATA_W-1:0] dat_wdata;
  logic              dat_oe;
  logic              miss_pulse;

  l2_wr_sequencer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .half_speed(half_speed),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .tag_oe_n(tag_oe_n), .tag_addr(tag_addr), .tag_rd_tag(tag_rd_tag), .tag_rd_state(tag_rd_state),
    .dat_we_n(dat_we_n), .dat_addr(dat_addr), .dat_wdata(dat_wdata), .dat_oe(dat_oe),
    .miss_pulse(miss_pulse)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // Tag SRAM model: synchronous, clocked at the SRAM cycle boundary (R8 pairing rule)
  logic [TAG_W-1:0] mem_tag [0:(1<<IDX_W)-1];
  logic [1:0]       mem_st  [0:(1<<IDX_W)-1];
  logic             phb = 1'b0;
  wire              advb = ~half_speed | phb;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) phb <= 1'b0;
    else if (half_speed) phb <= ~phb;
    else phb <= 1'b0;
    if (!rst && advb && !tag_oe_n) begin
      tag_rd_tag   <= mem_tag[tag_addr];
      tag_rd_state <= mem_st[tag_addr];
    end
  end

  // Output log, sampled away from the active edge
  logic             s_toe [0:LOGN-1];
  logic [IDX_W-1:0] s_tad [0:LOGN-1];
  logic             s_we  [0:LOGN-1];
  logic [IDX_W-1:0] s_dad [0:LOGN-1];
  logic             s_oe  [0:LOGN-1];
  logic [DATA_W-1:0] s_wd [0:LOGN-1];
  logic             s_mi  [0:LOGN-1];

  always @(negedge clk) begin
    s_toe[cyc % LOGN] <= tag_oe_n;
    s_tad[cyc % LOGN] <= tag_addr;
    s_we[cyc % LOGN]  <= dat_we_n;
    s_dad[cyc % LOGN] <= dat_addr;
    s_oe[cyc % LOGN]  <= dat_oe;
    s_wd[cyc % LOGN]  <= dat_wdata;
    s_mi[cyc % LOGN]  <= miss_pulse;
  end

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit half);
    @(negedge clk);
    rst = 1'b1;
    half_speed = half;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Burst stimulus
  int          b_n;
  logic [ADDR_W-1:0] b_addr [0:7];
  logic [DATA_W-1:0] b_dat  [0:7];
  int          b_k    [0:7];

  task automatic send_burst();
    for (int i = 0; i < b_n; i++) begin
      req_valid = 1'b1;
      req_addr  = b_addr[i];
      req_data  = b_dat[i];
      while (!req_ready) @(negedge clk);
      b_k[i] = cyc + 1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    req_addr  = '0;
    req_data  = '0;
  endtask

  task automatic verify(input string tn, input int k, input int idx, input logic [DATA_W-1:0] dat,
                        input bit hit, input int m);
    chk("R2", {tn, " tag strobe"}, 64'(s_toe[k % LOGN]), 64'd0);
    chk("R2", {tn, " tag addr"}, 64'(s_tad[k % LOGN]), 64'(idx));
    if (m == 2) chk("R8", {tn, " tag strobe held"}, 64'(s_toe[(k+1) % LOGN]), 64'd0);
    if (hit) begin
      chk("R6", {tn, " no miss on hit"}, 64'(s_mi[(k+3*m) % LOGN]), 64'd0);
      chk("R4", {tn, " data we_n"}, 64'(s_we[(k+4*m) % LOGN]), 64'd0);
      chk("R4", {tn, " data addr"}, 64'(s_dad[(k+4*m) % LOGN]), 64'(idx));
      chk("R5", {tn, " data oe"}, 64'(s_oe[(k+5*m) % LOGN]), 64'd1);
      chk("R5", {tn, " write data"}, 64'(s_wd[(k+5*m) % LOGN]), 64'(dat));
      if (m == 2) begin
        chk("R8", {tn, " we_n held"}, 64'(s_we[(k+4*m+1) % LOGN]), 64'd0);
        chk("R8", {tn, " data held"}, 64'(s_wd[(k+5*m+1) % LOGN]), 64'(dat));
        chk("R8", {tn, " oe held"}, 64'(s_oe[(k+5*m+1) % LOGN]), 64'd1);
      end
    end else begin
      chk("R6", {tn, " miss pulse"}, 64'(s_mi[(k+3*m) % LOGN]), 64'd1);
      chk("R6", {tn, " miss one clock"}, 64'(s_mi[(k+3*m+1) % LOGN]), 64'(m == 1 ? s_mi[(k+3*m+1) % LOGN] : 1'b0));
      chk("R6", {tn, " no we_n"}, 64'(s_we[(k+4*m) % LOGN]), 64'd1);
      chk("R6", {tn, " no oe"}, 64'(s_oe[(k+5*m) % LOGN]), 64'd0);
    end
  endtask

  task automatic count_we(input string tn, input int from, input int to, input int exp);
    int n = 0;
    for (int c = from; c <= to; c++) if (s_we[c % LOGN] == 1'b0) n++;
    chk("R9", {tn, " write strobe count"}, 64'(n), 64'(exp));
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int tg, input int idx);
    return {TAG_W'(tg), IDX_W'(idx)};
  endfunction

  task automatic t_reset();
    do_reset(1'b0);
    @(negedge clk);
    chk("R1", "tag_oe_n", 64'(tag_oe_n), 64'd1);
    chk("R1", "dat_we_n", 64'(dat_we_n), 64'd1);
    chk("R1", "dat_oe", 64'(dat_oe), 64'd0);
    chk("R1", "miss_pulse", 64'(miss_pulse), 64'd0);
    chk("R1", "dat_wdata", 64'(dat_wdata), 64'd0);
    chk("R7", "ready full speed", 64'(req_ready), 64'd1);
  endtask

  task automatic t_full_burst_mod();
    mem_tag[8'h11] = 12'h0A1; mem_st[8'h11] = 2'd3;
    mem_tag[8'h12] = 12'h0A2; mem_st[8'h12] = 2'd3;
    mem_tag[8'h13] = 12'h0A3; mem_st[8'h13] = 2'd3;
    b_n = 3;
    b_addr[0] = mk_addr(12'h0A1, 8'h11); b_dat[0] = 32'hD0D0_0001;
    b_addr[1] = mk_addr(12'h0A2, 8'h12); b_dat[1] = 32'hD0D0_0002;
    b_addr[2] = mk_addr(12'h0A3, 8'h13); b_dat[2] = 32'hD0D0_0003;
    send_burst();
    repeat (10) @(negedge clk);
    chk("R7", "burst consecutive 0-1", 64'(b_k[1] - b_k[0]), 64'd1);
    chk("R7", "burst consecutive 1-2", 64'(b_k[2] - b_k[1]), 64'd1);
    for (int i = 0; i < 3; i++) verify("full_mod", b_k[i], 8'h11 + i, b_dat[i], 1'b1, 1);
    count_we("full_mod", b_k[0], b_k[2] + 8, 3);
  endtask

  task automatic t_single(input string tn, input logic [1:0] st, input bit tag_ok, input bit hit);
    mem_tag[8'h40] = 12'h3C5; mem_st[8'h40] = st;
    b_n = 1;
    b_addr[0] = mk_addr(tag_ok ? 12'h3C5 : 12'h3C4, 8'h40);
    b_dat[0]  = 32'h1234_5678 ^ {30'd0, st};
    send_burst();
    repeat (10) @(negedge clk);
    verify(tn, b_k[0], 8'h40, b_dat[0], hit, 1);
    chk("R3", {tn, " outcome strobe"}, 64'(s_we[(b_k[0]+4) % LOGN]), 64'(!hit));
    chk("R5", {tn, " bus idle in addr cycle"}, 64'(s_wd[(b_k[0]+4) % LOGN]), 64'd0);
  endtask

  task automatic t_mixed_burst();
    mem_tag[8'h21] = 12'h111; mem_st[8'h21] = 2'd2;
    mem_tag[8'h22] = 12'h222; mem_st[8'h22] = 2'd1;
    mem_tag[8'h23] = 12'h333; mem_st[8'h23] = 2'd3;
    mem_tag[8'h24] = 12'h444; mem_st[8'h24] = 2'd3;
    b_n = 4;
    b_addr[0] = mk_addr(12'h111, 8'h21); b_dat[0] = 32'hAAAA_0001;
    b_addr[1] = mk_addr(12'h222, 8'h22); b_dat[1] = 32'hAAAA_0002;
    b_addr[2] = mk_addr(12'h333, 8'h23); b_dat[2] = 32'hAAAA_0003;
    b_addr[3] = mk_addr(12'h445, 8'h24); b_dat[3] = 32'hAAAA_0004;
    send_burst();
    repeat (10) @(negedge clk);
    verify("mixed", b_k[0], 8'h21, b_dat[0], 1'b1, 1);
    verify("mixed", b_k[1], 8'h22, b_dat[1], 1'b0, 1);
    verify("mixed", b_k[2], 8'h23, b_dat[2], 1'b1, 1);
    verify("mixed", b_k[3], 8'h24, b_dat[3], 1'b0, 1);
    count_we("mixed", b_k[0], b_k[3] + 8, 2);
  endtask

  task automatic t_half();
    bit r0, r1, r2;
    do_reset(1'b1);
    @(negedge clk); r0 = req_ready;
    @(negedge clk); r1 = req_ready;
    @(negedge clk); r2 = req_ready;
    chk("R8", "ready alternates a", 64'(r0 ^ r1), 64'd1);
    chk("R8", "ready alternates b", 64'(r1 ^ r2), 64'd1);
    mem_tag[8'h51] = 12'h051; mem_st[8'h51] = 2'd3;
    mem_tag[8'h52] = 12'h052; mem_st[8'h52] = 2'd0;
    mem_tag[8'h53] = 12'h053; mem_st[8'h53] = 2'd2;
    b_n = 3;
    b_addr[0] = mk_addr(12'h051, 8'h51); b_dat[0] = 32'hBEEF_0001;
    b_addr[1] = mk_addr(12'h052, 8'h52); b_dat[1] = 32'hBEEF_0002;
    b_addr[2] = mk_addr(12'h053, 8'h53); b_dat[2] = 32'hBEEF_0003;
    send_burst();
    repeat (16) @(negedge clk);
    chk("R8", "half accept spacing", 64'(b_k[1] - b_k[0]), 64'd2);
    verify("half", b_k[0], 8'h51, b_dat[0], 1'b1, 2);
    verify("half", b_k[1], 8'h52, b_dat[1], 1'b0, 2);
    verify("half", b_k[2], 8'h53, b_dat[2], 1'b1, 2);
    count_we("half", b_k[0], b_k[2] + 14, 4);
  endtask

  initial begin
    for (int i = 0; i < (1 << IDX_W); i++) begin
      mem_tag[i] = '0;
      mem_st[i]  = 2'd0;
    end
    t_reset();
    t_full_burst_mod();
    t_single("excl_hit", 2'd2, 1'b1, 1'b1);
    t_single("shared_upgrade", 2'd1, 1'b1, 1'b0);
    t_single("invalid_line", 2'd0, 1'b1, 1'b0);
    t_single("tag_mismatch", 2'd3, 1'b0, 1'b0);
    t_mixed_burst();
    t_half();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule